// File: doc/BRIEF.md
# Output Virtual-Channel Allocator with Timeout Escape

This block hands out the virtual channels (VCs) of one router output port to packets waiting in the input VC buffers. Route computation has already run when a head flit raises its request. Later flits of the packet reuse the channel the head flit won. The highest-numbered output VC is kept aside as an escape lane. Ordinary packets never receive it.

For each input VC the block measures how long a buffered packet has gone without moving a flit. When that stall time reaches a set limit, the packet is marked as deadlocked. If it held an ordinary output VC, that VC is released at once. The packet then gets the escape VC as soon as the escape VC is free. While marked, the packet must take dimension-order (XY) routes, and the route logic reads this from the deadlock flag. A forwarded tail flit frees whatever output VC its packet held and clears the flag.

Top module: `vc_alloc_recovery`

## Requirements
- R1: After reset, no input holds an output VC, no deadlock flag is set and no output VC is marked busy.
- R2: A request from an input that holds no VC and is not flagged receives the lowest-numbered free ordinary VC (index 0 to NVC-2) at the next clock edge. At most one ordinary grant is made per cycle. `alloc_vc` holds the index in bits [i*VW +: VW] for input i.
- R3: Competing requesters are served round-robin. The search starts at input 0 after reset and, after each ordinary grant, at the input just above the one granted.
- R4: The escape VC (index NVC-1) is never given to a packet that is not flagged. When all ordinary VCs are busy, requests wait.
- R5: A per-input wait counter counts the edges at which the buffer is non-empty and no flit is forwarded, up to WAIT_LIMIT. Forwarding any flit, or an empty buffer, sets it back to zero. The deadlock flag rises at the edge where the counter already stands at WAIT_LIMIT and the input is still stalled, which is stall edge WAIT_LIMIT+1 in an unbroken run.
- R6: At the edge where a packet is flagged, any ordinary VC it held is released: its `alloc_valid` bit and the VC's `vc_busy` bit both fall.
- R7: A flagged packet that holds no VC receives the escape VC at the first edge at which the escape VC was free before that edge; the lowest-numbered flagged input wins. `xy_route` reports the flag.
- R8: While the escape VC is busy, a flagged packet keeps its flag and holds nothing. It is granted only at the edge after the escape VC's tail flit frees it.
- R9: Forwarding a tail flit from an input that holds a VC frees that VC and clears the input's flag at that edge. A non-tail forward frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_req | input | NIN | Head flit past route computation requests a VC on this port |
| buf_nonempty | input | NIN | Input VC buffer holds a flit of the packet |
| fwd | input | NIN | A flit of this input's packet is forwarded this cycle |
| fwd_tail | input | NIN | The forwarded flit is the tail |
| alloc_valid | output | NIN | Input holds an output VC |
| alloc_vc | output | NIN*VW | Output VC held by each input |
| xy_route | output | NIN | Packet is flagged as deadlocked and must route XY |
| vc_busy | output | NVC | Output VC is reserved |

## Verification
The hardest case is a flagged packet that finds the escape VC already held by an earlier flagged packet, so its wait spans that holder's tail. The stimulus builds it in order. One input stalls until it is flagged, loses its ordinary VC and takes the escape lane. A second input then stalls past the limit while the first still holds the escape lane. The first input's tail is forwarded only after the second input's flag has been checked for several cycles with no grant. A forward without a tail is placed in the middle of a stall run to show that the counter starts again from zero.

// File: rtl/vc_alloc_recovery.sv
module vc_alloc_recovery #(
  parameter int NIN = 4,
  parameter int NVC = 4,
  parameter int WAIT_LIMIT = 32,
  parameter int VW = $clog2(NVC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIN-1:0]    head_req,
  input  logic [NIN-1:0]    buf_nonempty,
  input  logic [NIN-1:0]    fwd,
  input  logic [NIN-1:0]    fwd_tail,
  output logic [NIN-1:0]    alloc_valid,
  output logic [NIN*VW-1:0] alloc_vc,
  output logic [NIN-1:0]    xy_route,
  output logic [NVC-1:0]    vc_busy
);
  localparam int IW = $clog2(NIN);
  localparam int CW = $clog2(WAIT_LIMIT + 1);
  localparam int ESC = NVC - 1;
  localparam logic [CW-1:0] LIM = CW'(WAIT_LIMIT);

  logic [NIN-1:0] held_q, dl_q;
  logic [VW-1:0]  vc_q  [NIN];
  logic [CW-1:0]  cnt_q [NIN];
  logic [NVC-1:0] busy_q, busy_d;
  logic [IW-1:0]  ptr_q;

  logic [NIN-1:0] dl_now, rel, cand, esc_cand;
  logic           free_ok, pick_ok, esc_ok;
  logic [VW-1:0]  free_idx;
  logic [IW-1:0]  pick_idx, esc_idx;
  logic           ngrant;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      dl_now[i] = buf_nonempty[i] & ~fwd[i] & (cnt_q[i] == LIM) & ~dl_q[i];
      rel[i]    = fwd[i] & fwd_tail[i] & held_q[i];
    end
  end

  assign cand     = head_req & ~held_q & ~dl_q & ~dl_now;
  assign esc_cand = dl_q & ~held_q;

  always_comb begin
    free_ok = 1'b0;
    free_idx = '0;
    for (int v = 0; v < ESC; v++)
      if (!free_ok && !busy_q[v]) begin
        free_ok = 1'b1;
        free_idx = VW'(v);
      end
  end

  always_comb begin
    pick_ok = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < NIN; k++)
      if (!pick_ok && cand[(int'(ptr_q) + k) % NIN]) begin
        pick_ok = 1'b1;
        pick_idx = IW'((int'(ptr_q) + k) % NIN);
      end
  end

  always_comb begin
    esc_ok = 1'b0;
    esc_idx = '0;
    for (int i = 0; i < NIN; i++)
      if (!esc_ok && esc_cand[i]) begin
        esc_ok = 1'b1;
        esc_idx = IW'(i);
      end
    esc_ok = esc_ok & ~busy_q[ESC];
  end

  assign ngrant = pick_ok & free_ok;

  always_comb begin
    busy_d = busy_q;
    for (int i = 0; i < NIN; i++)
      if (held_q[i] && (rel[i] || dl_now[i])) busy_d[vc_q[i]] = 1'b0;
    if (ngrant) busy_d[free_idx] = 1'b1;
    if (esc_ok) busy_d[ESC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      dl_q   <= '0;
      busy_q <= '0;
      ptr_q  <= '0;
      for (int i = 0; i < NIN; i++) begin
        vc_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      busy_q <= busy_d;
      if (ngrant) ptr_q <= IW'((int'(pick_idx) + 1) % NIN);
      for (int i = 0; i < NIN; i++) begin
        if (!buf_nonempty[i] || fwd[i]) cnt_q[i] <= '0;
        else if (cnt_q[i] != LIM) cnt_q[i] <= cnt_q[i] + 1'b1;

        if (rel[i]) dl_q[i] <= 1'b0;
        else if (dl_now[i]) dl_q[i] <= 1'b1;

        if (rel[i] || dl_now[i]) held_q[i] <= 1'b0;
        else if (ngrant && pick_idx == IW'(i)) begin
          held_q[i] <= 1'b1;
          vc_q[i]   <= free_idx;
        end else if (esc_ok && esc_idx == IW'(i)) begin
          held_q[i] <= 1'b1;
          vc_q[i]   <= VW'(ESC);
        end
      end
    end
  end

  assign alloc_valid = held_q;
  assign xy_route    = dl_q;
  assign vc_busy     = busy_q;

  for (genvar g = 0; g < NIN; g++) begin : g_out
    assign alloc_vc[g*VW +: VW] = vc_q[g];

    p_esc_only_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q[g] && vc_q[g] == VW'(ESC)) |-> dl_q[g]);
    p_release_on_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dl_q[g]) |-> !held_q[g]);
    p_flag_after_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dl_q[g]) |-> $past(buf_nonempty[g] && !fwd[g]));
    p_tail_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd[g] && fwd_tail[g] && held_q[g]) |=> (!held_q[g] && !dl_q[g]));
    p_esc_busy_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_q[g] && !held_q[g] && busy_q[ESC]) |=> !held_q[g]);
  end

  p_busy_matches_holders_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_q) == $countones(held_q));
endmodule

// File: tb/vc_alloc_recovery_test.sv
module vc_alloc_recovery_test;
  localparam int NIN = 4, NVC = 4, VW = 2, LIM = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN-1:0] head_req = '0, buf_nonempty = '0, fwd = '0, fwd_tail = '0;
  logic [NIN-1:0] alloc_valid, xy_route;
  logic [NIN*VW-1:0] alloc_vc;
  logic [NVC-1:0] vc_busy;

  always #2.5 clk = ~clk;

  vc_alloc_recovery #(.NIN(NIN), .NVC(NVC), .WAIT_LIMIT(LIM), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .head_req(head_req), .buf_nonempty(buf_nonempty),
    .fwd(fwd), .fwd_tail(fwd_tail), .alloc_valid(alloc_valid), .alloc_vc(alloc_vc),
    .xy_route(xy_route), .vc_busy(vc_busy));

  typedef struct {
    string tag;
    logic [3:0] av;
    logic [7:0] vc;
    logic [3:0] dl;
    logic [3:0] ob;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [7:0] mask;
      e = q.pop_front();
      mask = '0;
      for (int i = 0; i < NIN; i++) if (e.av[i]) mask[i*VW +: VW] = '1;
      checks++;
      if (alloc_valid !== e.av || (alloc_vc & mask) !== (e.vc & mask) ||
          xy_route !== e.dl || vc_busy !== e.ob) begin
        errors++;
        $display("FAIL %s: got av=%b vc=%h dl=%b busy=%b, expected av=%b vc=%h dl=%b busy=%b",
                 e.tag, alloc_valid, alloc_vc & mask, xy_route, vc_busy,
                 e.av, e.vc & mask, e.dl, e.ob);
      end
    end
  end

  task automatic step(string tag, logic [3:0] rq, logic [3:0] fw, logic [3:0] tl,
                      logic [3:0] ne, logic [3:0] av, logic [7:0] vc,
                      logic [3:0] dl, logic [3:0] ob);
    head_req = rq; fwd = fw; fwd_tail = tl; buf_nonempty = ne;
    @(posedge clk);
    #1;
    q.push_back('{tag, av, vc, dl, ob});
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step("R1 reset state", 0, 0, 0, 0, 4'b0000, 8'h00, 4'b0000, 4'b0000);
    rst_n = 1'b1;
    step("R2 first grant lowest VC", 4'b0110, 0, 0, 0, 4'b0010, 8'h00, 4'b0000, 4'b0001);
    step("R3 next requester gets VC1", 4'b0100, 0, 0, 0, 4'b0110, 8'h10, 4'b0000, 4'b0011);
    step("R3 round robin favours input3", 4'b1001, 0, 0, 0, 4'b1110, 8'h90, 4'b0000, 4'b0111);
    step("R4 escape withheld", 4'b0001, 0, 0, 0, 4'b1110, 8'h90, 4'b0000, 4'b0111);
    step("R9 tail frees VC0", 4'b0001, 4'b0010, 4'b0010, 0, 4'b1100, 8'h90, 4'b0000, 4'b0110);
    step("R2 freed VC0 regranted", 4'b0001, 0, 0, 0, 4'b1101, 8'h90, 4'b0000, 4'b0111);
    for (int k = 0; k < LIM; k++)
      step("R5 no flag before limit", 0, 0, 0, 4'b0100, 4'b1101, 8'h90, 4'b0000, 4'b0111);
    step("R6 flag releases VC1", 0, 0, 0, 4'b0100, 4'b1001, 8'h80, 4'b0100, 4'b0101);
    step("R7 escape granted", 0, 0, 0, 4'b0100, 4'b1101, 8'hB0, 4'b0100, 4'b1101);
    for (int k = 0; k < LIM; k++)
      step("R5 second stall counting", 0, 0, 0, 4'b1000, 4'b1101, 8'hB0, 4'b0100, 4'b1101);
    step("R6 input3 flagged releases VC2", 0, 0, 0, 4'b1000, 4'b0101, 8'h30, 4'b1100, 4'b1001);
    step("R8 escape busy waits", 0, 0, 0, 4'b1000, 4'b0101, 8'h30, 4'b1100, 4'b1001);
    step("R8 escape tail frees, no grant yet", 0, 4'b0100, 4'b0100, 4'b1000,
         4'b0001, 8'h00, 4'b1000, 4'b0001);
    step("R7 waiting packet gets escape", 0, 0, 0, 4'b1000, 4'b1001, 8'hC0, 4'b1000, 4'b1001);
    for (int k = 0; k < 5; k++)
      step("R5 partial stall", 0, 0, 0, 4'b0001, 4'b1001, 8'hC0, 4'b1000, 4'b1001);
    step("R5 R9 body forward resets count, keeps VC", 0, 4'b0001, 0, 4'b0001,
         4'b1001, 8'hC0, 4'b1000, 4'b1001);
    for (int k = 0; k < LIM; k++)
      step("R5 restarted count below limit", 0, 0, 0, 4'b0001, 4'b1001, 8'hC0, 4'b1000, 4'b1001);
    step("R6 input0 flagged releases VC0", 0, 0, 0, 4'b0001, 4'b1000, 8'hC0, 4'b1001, 4'b1000);
    step("R8 escape held by input3", 0, 0, 0, 4'b0001, 4'b1000, 8'hC0, 4'b1001, 4'b1000);
    step("R9 escape tail clears flag", 0, 4'b1000, 4'b1000, 4'b0001, 4'b0000, 8'h00, 4'b0001, 4'b0000);
    step("R7 input0 takes escape", 0, 0, 0, 4'b0001, 4'b0001, 8'h03, 4'b0001, 4'b1000);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule